// File: doc/BRIEF.md
# Command/Address Forwarder with Mode-Write Snooping

This block sits between the memory controller and the DRAM command pins. It copies the controller's 14-bit address and its active-low chip select onto the CA bus and the CS output. It also copies the controller's DRAM reset onto the DRAM reset pin. Every one of these outputs is registered once, so each lags its input by exactly one clock.

While commands pass through, the block watches them. A command occupies two CA cycles. The first cycle is the one with CS low, and it carries the opcode. When the command is a mode register write aimed at one of three snooped mode registers, the operand carried in the second cycle updates a local copy of the write settings. These settings are the burst length, the preamble length, the postamble length and the write CRC enable. The write serializer reads these settings directly.

When the command is a write, the block raises a one-cycle start pulse. The pulse carries the burst length for that write. That length is either the fixed default of 16 or the alternative length stored from the last accepted burst-length mode write. The pulse is aligned with the cycle in which the write's first CA cycle appears on the CA output.

Top module: `ca_cmd_mapper`

## Requirements
- R1: `ca_out` and `cs_out_n` equal `ctl_addr` and `ctl_cs_n` as sampled at the previous rising clock edge.
- R2: `dram_reset_n` follows `ctl_reset_n` with one clock of latency. While `rst_n` is low at a clock edge, the block drives `ca_out` to 0, `cs_out_n` to 1 and `dram_reset_n` to 0.
- R3: After reset, the stored settings are: `cfg_burst` = 00 (BL16), `cfg_pre` = 00 (one-cycle preamble), `cfg_post` = 0 (half-cycle postamble) and `cfg_crc_en` = 0.
- R4: The command field is CA[4:0], and the mode register address field is CA[12:5], both in the first cycle. The operand is CA[7:0] of the second cycle. A mode write uses command field 00101. A mode write to address 0 loads operand bits [1:0] into `cfg_burst`, where 00 = BL16, 01 = BC8 on the fly and 10 = BL32. The reserved code 11 is ignored.
- R5: A mode write to address 8 loads operand bits [1:0] into `cfg_pre` (codes 00 to 11 mean 1 to 4 cycles). The same write loads operand bit 4 into `cfg_post` (0 = half cycle, 1 = one and a half cycles).
- R6: A mode write to address 50 loads operand bit 1 into `cfg_crc_en`.
- R7: Mode writes to any other address, and all commands that are not mode writes, leave every stored setting unchanged.
- R8: A write command uses command field 01101 with CS low in its first cycle. It raises `wr_go` for exactly one cycle, in the same cycle that its first CA cycle appears on `ca_out`.
- R9: With `wr_go` high, `wr_burst` is 00 (BL16) when CA[5] of the write's first cycle was 1. When CA[5] was 0, `wr_burst` is the stored `cfg_burst` value.
- R10: The cycle after a command's first cycle is always treated as that command's second cycle. It never starts a command, even when CS is low and it carries a valid command field.
- R11: A mode write's new settings appear in the cycle its second CA cycle appears on `ca_out`. A write whose first cycle directly follows that second cycle uses the new burst length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_addr | input | 14 | Controller command/address word |
| ctl_cs_n | input | 1 | Controller chip select, active low |
| ctl_reset_n | input | 1 | Controller request for DRAM reset, active low |
| ca_out | output | 14 | CA bus to the DRAM |
| cs_out_n | output | 1 | Chip select to the DRAM, active low |
| dram_reset_n | output | 1 | Reset pin to the DRAM, active low |
| wr_go | output | 1 | One-cycle write start pulse |
| wr_burst | output | 2 | Burst length for the write flagged by `wr_go` |
| cfg_burst | output | 2 | Stored alternative burst length code |
| cfg_pre | output | 2 | Stored preamble length code |
| cfg_post | output | 1 | Stored postamble length select |
| cfg_crc_en | output | 1 | Stored write CRC enable |

## Verification
The hardest cases to reach are those in which the second CA cycle looks like a command of its own. This happens when that cycle has CS low and a valid write or mode-write field, and the block must treat it as an operand.

The bench creates these cases by driving two CS-low cycles back to back, with a command pattern in the second one. It then checks two things: that no write pulse appears, and that the stored settings take exactly the operand bits.

A second timing case is a write that follows directly after a burst-length mode write. The bench drives this and checks that the write picks up the new value with no idle cycle in between.

// File: rtl/ca_map_pkg.sv
// Package ca_map_pkg
// Shared field positions, command codes and setting types for the
// command/address forwarder. Assumes a CA word of at least 14 bits.
package ca_map_pkg;

    localparam int OPC_LSB = 0;
    localparam int OPC_W   = 5;
    localparam int MRA_LSB = 5;
    localparam int MRA_W   = 8;
    localparam int OPD_W   = 8;
    localparam int BLSEL_BIT = 5;

    localparam logic [OPC_W-1:0] OPC_MODE_WR = 5'b00101;
    localparam logic [OPC_W-1:0] OPC_WRITE   = 5'b01101;

    typedef enum logic [1:0] {
        BURST_16  = 2'b00,
        BURST_C8  = 2'b01,
        BURST_32  = 2'b10,
        BURST_RSV = 2'b11
    } burst_e;

    typedef enum logic [1:0] {
        SLOT_FREE  = 2'b00,
        SLOT_MODE  = 2'b01,
        SLOT_OTHER = 2'b10
    } slot_e;

    typedef struct packed {
        burst_e     burst;
        logic [1:0] pre;
        logic       post;
        logic       crc_en;
    } wr_cfg_t;

    localparam wr_cfg_t CFG_RESET = '{burst: BURST_16, pre: 2'b00,
                                      post: 1'b0, crc_en: 1'b0};

endpackage

// File: rtl/ca_fwd_stage.sv
// Module ca_fwd_stage
// Registers the controller CA word, chip select and DRAM reset once,
// giving a fixed one-cycle pin latency. Assumes a synchronous active-low
// reset, during which the DRAM is held in reset and deselected.
module ca_fwd_stage #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] addr_in,
    input  logic         cs_n_in,
    input  logic         rst_in_n,
    output logic [W-1:0] addr_out,
    output logic         cs_n_out,
    output logic         dram_rst_n_out
);

    // Pin register: one-cycle copy of the controller signals.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_out       <= '0;
            cs_n_out       <= 1'b1;
            dram_rst_n_out <= 1'b0;
        end else begin
            addr_out       <= addr_in;
            cs_n_out       <= cs_n_in;
            dram_rst_n_out <= rst_in_n;
        end
    end

    // R1
    ca_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (addr_out == $past(addr_in)) && (cs_n_out == $past(cs_n_in)));

    // R2
    rst_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> dram_rst_n_out == $past(rst_in_n));

endmodule

// File: rtl/ca_cmd_track.sv
// Module ca_cmd_track
// Follows the two-cycle command framing. A CS-low cycle while no command is
// open starts a command. The cycle after it is the second cycle, whatever
// CS does then. Reports write starts at once and completed mode writes
// (address plus operand) during their second cycle.
module ca_cmd_track
    import ca_map_pkg::*;
#(
    parameter int W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     addr,
    input  logic             cs_n,
    output logic             wr_start,
    output logic             wr_sel_default,
    output logic             mode_done,
    output logic [MRA_W-1:0] mode_addr,
    output logic [OPD_W-1:0] mode_opd
);

    slot_e             slot_q;
    logic [MRA_W-1:0]  mra_q;
    logic [OPC_W-1:0]  opc;
    logic              cmd_start;

    // Field split of the incoming word.
    always_comb begin
        opc = addr[OPC_LSB +: OPC_W];
    end

    // A command can begin only when no second cycle is due.
    always_comb begin
        cmd_start      = (slot_q == SLOT_FREE) && !cs_n;
        wr_start       = cmd_start && (opc == OPC_WRITE);
        wr_sel_default = addr[BLSEL_BIT];
        mode_done      = (slot_q == SLOT_MODE);
        mode_addr      = mra_q;
        mode_opd       = addr[OPD_W-1:0];
    end

    // Slot register: remembers that the next cycle is a second cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= SLOT_FREE;
            mra_q  <= '0;
        end else begin
            case (slot_q)
                SLOT_FREE: begin
                    if (!cs_n) begin
                        slot_q <= (opc == OPC_MODE_WR) ? SLOT_MODE : SLOT_OTHER;
                        mra_q  <= addr[MRA_LSB +: MRA_W];
                    end
                end
                default: slot_q <= SLOT_FREE;
            endcase
        end
    end

    // R10
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> !cmd_start);

    // R10
    slot_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q != 2'b11);

endmodule

// File: rtl/ca_mode_store.sv
// Module ca_mode_store
// Holds the PHY-side copy of the write settings. It updates them from
// completed mode writes whose address matches one of the three snooped
// registers. Reserved burst codes are dropped, and the old value is kept.
module ca_mode_store
    import ca_map_pkg::*;
#(
    parameter logic [MRA_W-1:0] MR_BURST = 8'd0,
    parameter logic [MRA_W-1:0] MR_AMBLE = 8'd8,
    parameter logic [MRA_W-1:0] MR_CRC   = 8'd50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_done,
    input  logic [MRA_W-1:0] mode_addr,
    input  logic [OPD_W-1:0] mode_opd,
    output wr_cfg_t          cfg
);

    logic hit_burst, hit_amble, hit_crc, burst_ok;

    // Address match for each snooped register.
    always_comb begin
        hit_burst = mode_done && (mode_addr == MR_BURST);
        hit_amble = mode_done && (mode_addr == MR_AMBLE);
        hit_crc   = mode_done && (mode_addr == MR_CRC);
        burst_ok  = (mode_opd[1:0] != BURST_RSV);
    end

    // Settings register: field-wise load from matched mode writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= CFG_RESET;
        end else begin
            if (hit_burst && burst_ok) cfg.burst  <= burst_e'(mode_opd[1:0]);
            if (hit_amble) begin
                cfg.pre  <= mode_opd[1:0];
                cfg.post <= mode_opd[4];
            end
            if (hit_crc)   cfg.crc_en <= mode_opd[1];
        end
    end

    // R4
    legal_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.burst != BURST_RSV);

    // R7
    quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(mode_done) |-> $stable(cfg));

    // R7
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_burst, hit_amble, hit_crc}));

endmodule

// File: rtl/ca_burst_pick.sv
// Module ca_burst_pick
// Turns a write start into a registered one-cycle pulse with its burst
// length. The length is either the fixed default or the stored
// alternative, chosen by the select bit of the write's first cycle.
// Registering here keeps the pulse aligned with the forwarded CA word.
module ca_burst_pick
    import ca_map_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_start,
    input  logic   wr_sel_default,
    input  burst_e alt_burst,
    output logic   wr_go,
    output burst_e wr_burst
);

    // Pulse register: capture start and resolved burst length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_go    <= 1'b0;
            wr_burst <= BURST_16;
        end else begin
            wr_go <= wr_start;
            if (wr_start) wr_burst <= wr_sel_default ? BURST_16 : alt_burst;
        end
    end

    // R8
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> !wr_go);

    // R9
    default_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && wr_go && $past(wr_sel_default) |-> wr_burst == BURST_16);

    // R9
    alt_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && wr_go && !$past(wr_sel_default) |-> wr_burst == $past(alt_burst));

endmodule

// File: rtl/ca_cmd_mapper.sv
// Module ca_cmd_mapper
// Top of the command/address path. It forwards CA, CS and DRAM reset with
// one cycle of latency, snoops mode writes into the write settings, and
// flags writes with their resolved burst length. Assumes the controller
// keeps to two-cycle command framing.
module ca_cmd_mapper
    import ca_map_pkg::*;
#(
    parameter int               ADDR_W   = 14,
    parameter logic [MRA_W-1:0] MR_BURST = 8'd0,
    parameter logic [MRA_W-1:0] MR_AMBLE = 8'd8,
    parameter logic [MRA_W-1:0] MR_CRC   = 8'd50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ctl_addr,
    input  logic              ctl_cs_n,
    input  logic              ctl_reset_n,
    output logic [ADDR_W-1:0] ca_out,
    output logic              cs_out_n,
    output logic              dram_reset_n,
    output logic              wr_go,
    output logic [1:0]        wr_burst,
    output logic [1:0]        cfg_burst,
    output logic [1:0]        cfg_pre,
    output logic              cfg_post,
    output logic              cfg_crc_en
);

    localparam int FIELD_TOP = MRA_LSB + MRA_W;

    logic             wr_start, wr_sel_default, mode_done;
    logic [MRA_W-1:0] mode_addr;
    logic [OPD_W-1:0] mode_opd;
    wr_cfg_t          cfg;
    burst_e           burst_q;

    ca_fwd_stage #(.W(ADDR_W)) i_fwd (
        .clk(clk), .rst_n(rst_n),
        .addr_in(ctl_addr), .cs_n_in(ctl_cs_n), .rst_in_n(ctl_reset_n),
        .addr_out(ca_out), .cs_n_out(cs_out_n), .dram_rst_n_out(dram_reset_n)
    );

    ca_cmd_track #(.W(ADDR_W)) i_track (
        .clk(clk), .rst_n(rst_n), .addr(ctl_addr), .cs_n(ctl_cs_n),
        .wr_start(wr_start), .wr_sel_default(wr_sel_default),
        .mode_done(mode_done), .mode_addr(mode_addr), .mode_opd(mode_opd)
    );

    ca_mode_store #(.MR_BURST(MR_BURST), .MR_AMBLE(MR_AMBLE), .MR_CRC(MR_CRC)) i_store (
        .clk(clk), .rst_n(rst_n), .mode_done(mode_done),
        .mode_addr(mode_addr), .mode_opd(mode_opd), .cfg(cfg)
    );

    ca_burst_pick i_pick (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start),
        .wr_sel_default(wr_sel_default), .alt_burst(cfg.burst),
        .wr_go(wr_go), .wr_burst(burst_q)
    );

    // Flatten the settings struct onto plain output ports.
    always_comb begin
        wr_burst   = burst_q;
        cfg_burst  = cfg.burst;
        cfg_pre    = cfg.pre;
        cfg_post   = cfg.post;
        cfg_crc_en = cfg.crc_en;
    end

    // Field layout needs the mode address to fit in the CA word.
    initial begin
        width_fit_chk: assert (FIELD_TOP <= ADDR_W);
    end

    // R8
    pulse_on_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> !cs_out_n);

    // R11
    update_on_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(rst_n, 2) && !$stable(cfg) |-> $past(!ctl_cs_n, 2));

endmodule

// File: tb/test_ca_cmd_mapper.sv
// Directed bench for ca_cmd_mapper. It drives inputs on falling edges and
// samples one falling edge later, after the single register stage.
module test_ca_cmd_mapper;

    localparam logic [4:0] C_MODE = 5'b00101;
    localparam logic [4:0] C_WR   = 5'b01101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] ctl_addr = '0;
    logic        ctl_cs_n = 1'b1;
    logic        ctl_reset_n = 1'b1;
    logic [13:0] ca_out;
    logic        cs_out_n, dram_reset_n, wr_go, cfg_post, cfg_crc_en;
    logic [1:0]  wr_burst, cfg_burst, cfg_pre;

    int n_chk = 0;
    int n_bad = 0;
    logic [1:0] e_burst = 2'b00;
    logic [1:0] e_pre = 2'b00;
    logic       e_post = 1'b0;
    logic       e_crc = 1'b0;

    always #5 clk = ~clk;

    ca_cmd_mapper i_ca_cmd_mapper (
        .clk(clk), .rst_n(rst_n), .ctl_addr(ctl_addr), .ctl_cs_n(ctl_cs_n),
        .ctl_reset_n(ctl_reset_n), .ca_out(ca_out), .cs_out_n(cs_out_n),
        .dram_reset_n(dram_reset_n), .wr_go(wr_go), .wr_burst(wr_burst),
        .cfg_burst(cfg_burst), .cfg_pre(cfg_pre), .cfg_post(cfg_post),
        .cfg_crc_en(cfg_crc_en)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [13:0] a, input logic c);
        ctl_addr = a;
        ctl_cs_n = c;
        @(negedge clk);
    endtask

    task automatic chk_cfg(input string tag);
        chk({tag, " burst"}, 32'(cfg_burst), 32'(e_burst));
        chk({tag, " pre"},   32'(cfg_pre),   32'(e_pre));
        chk({tag, " post"},  32'(cfg_post),  32'(e_post));
        chk({tag, " crc"},   32'(cfg_crc_en), 32'(e_crc));
    endtask

    task automatic mode_wr(input logic [7:0] mra, input logic [7:0] opd);
        step({1'b0, mra, C_MODE}, 1'b0);
        step({6'b0, opd}, 1'b1);
    endtask

    task automatic write_cmd(input logic sel, input logic [1:0] exp_bl, input string tag);
        step({8'b0, sel, C_WR}, 1'b0);
        chk({tag, " wr_go"}, 32'(wr_go), 32'd1);
        chk({tag, " wr_burst"}, 32'(wr_burst), 32'(exp_bl));
        step(14'h0, 1'b1);
        chk({tag, " wr_go drop"}, 32'(wr_go), 32'd0);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        ctl_addr = 14'h3FFF;
        ctl_cs_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R2 ca in reset", 32'(ca_out), 32'h0);
        chk("R2 cs in reset", 32'(cs_out_n), 32'd1);
        chk("R2 dram reset held", 32'(dram_reset_n), 32'd0);
        chk("R8 no pulse in reset", 32'(wr_go), 32'd0);
        chk_cfg("R3 reset");
        rst_n = 1'b1;
        step(14'h0, 1'b1);
        chk("R2 reset forwarded", 32'(dram_reset_n), 32'd1);
        chk_cfg("R3 after release");
    endtask

    task automatic t_forward;
        step(14'h2A5C, 1'b1);
        chk("R1 ca pattern a", 32'(ca_out), 32'h2A5C);
        chk("R1 cs high", 32'(cs_out_n), 32'd1);
        step(14'h15BF, 1'b0);
        chk("R1 ca pattern b", 32'(ca_out), 32'h15BF);
        chk("R1 cs low", 32'(cs_out_n), 32'd0);
        step(14'h3FFF, 1'b1);
        chk("R1 ca all ones", 32'(ca_out), 32'h3FFF);
        ctl_reset_n = 1'b0;
        step(14'h0, 1'b1);
        chk("R2 dram reset low", 32'(dram_reset_n), 32'd0);
        chk("R1 ca zero", 32'(ca_out), 32'h0);
        ctl_reset_n = 1'b1;
        step(14'h0, 1'b1);
        chk("R2 dram reset high", 32'(dram_reset_n), 32'd1);
    endtask

    task automatic t_burst_mode;
        mode_wr(8'd0, 8'h02);
        e_burst = 2'b10;
        chk_cfg("R4 load BL32");
        mode_wr(8'd0, 8'hFF);
        chk_cfg("R4 reserved ignored");
        mode_wr(8'd0, 8'h01);
        e_burst = 2'b01;
        chk_cfg("R4 load BC8");
    endtask

    task automatic t_amble_crc;
        mode_wr(8'd8, 8'h13);
        e_pre = 2'b11;
        e_post = 1'b1;
        chk_cfg("R5 amble set");
        mode_wr(8'd8, 8'hEE);
        e_pre = 2'b10;
        e_post = 1'b0;
        chk_cfg("R5 amble second");
        mode_wr(8'd50, 8'h02);
        e_crc = 1'b1;
        chk_cfg("R6 crc on");
        mode_wr(8'd50, 8'hFD);
        e_crc = 1'b0;
        chk_cfg("R6 crc off");
        mode_wr(8'd50, 8'h02);
        e_crc = 1'b1;
        chk_cfg("R6 crc on again");
    endtask

    task automatic t_other;
        mode_wr(8'd3, 8'hFF);
        chk_cfg("R7 other address");
        mode_wr(8'd1, 8'h00);
        chk_cfg("R7 neighbour address");
        step({1'b0, 8'd0, 5'b00001}, 1'b0);
        step(14'h0002, 1'b1);
        chk_cfg("R7 non-mode command");
        step(14'h0, 1'b1);
    endtask

    task automatic t_write;
        write_cmd(1'b1, 2'b00, "R9 default select");
        write_cmd(1'b0, 2'b01, "R9 alt BC8");
        mode_wr(8'd0, 8'h02);
        e_burst = 2'b10;
        step(14'h0, 1'b1);
        write_cmd(1'b0, 2'b10, "R8 alt BL32");
        write_cmd(1'b1, 2'b00, "R8 default after BL32");
    endtask

    task automatic t_second_cycle;
        step({8'b0, 1'b1, C_WR}, 1'b0);
        chk("R10 first pulse", 32'(wr_go), 32'd1);
        step({8'b0, 1'b1, C_WR}, 1'b0);
        chk("R10 second cycle not a write", 32'(wr_go), 32'd0);
        chk("R10 second cycle forwarded", 32'(ca_out), 32'(14'h002D));
        step(14'h0, 1'b1);
        chk("R10 idle after", 32'(wr_go), 32'd0);
        step({1'b0, 8'd0, C_MODE}, 1'b0);
        step({1'b0, 8'd0, C_MODE}, 1'b0);
        e_burst = 2'b01;
        chk_cfg("R10 mode-like operand");
        step(14'h0, 1'b1);
        chk("R10 no pulse after mode", 32'(wr_go), 32'd0);
    endtask

    task automatic t_back_to_back;
        step({1'b0, 8'd0, C_MODE}, 1'b0);
        chk_cfg("R11 unchanged on first cycle");
        step(14'h0002, 1'b1);
        e_burst = 2'b10;
        chk_cfg("R11 visible with second cycle");
        write_cmd(1'b0, 2'b10, "R11 write right after");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_forward();
        t_burst_mode();
        t_amble_crc();
        t_other();
        t_write();
        t_second_cycle();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule